// File: doc/BRIEF.md
# Banked TLB Register Access Port

This block gives software a register-level path into a small translation buffer. The buffer has two banks, each holding four sets of sixteen entries, and each entry is a pair of 32-bit words: an upper (tag) word and a lower (attribute) word. Software reaches the buffer through a banked special-register file. A 2-bit bank selector picks one of four register banks. Selector values 1 and 2 are TLB-capable and map to buffer banks 0 and 1. Values 0 and 3 reach only plain storage.

Four special registers carry the buffer side effects: an entry-select register (number 4), a lower-word register (number 5), an upper-word register (number 6) and a cause register (number 7). Writing the upper-word register also updates the cause register. Writing the lower-word register commits an entry. That entry takes its lower word from the write and its upper word from the cause register.

When the entry being replaced was valid, the block emits a one-cycle page-invalidate pulse that carries the old virtual page number. Any read made while a TLB-capable bank is selected first refreshes the upper and lower mirror registers from the addressed entry.

Top module: `tlb_regport`

## Requirements
- R1: After reset, `rsp_valid`, `inval_valid` and `inval_vpn` are zero, every register reads zero, and every entry is zero (and therefore invalid).
- R2: A read request returns data on `rsp_rdata` with `rsp_valid` high exactly one cycle later. Writing a register with no side effect (numbers 0–4, 8–15) and reading it back in the same bank returns the written value.
- R3: With selector 1 or 2, a write to register 6 also stores the same value into register 7 of that bank.
- R4: With selector 1 or 2, a write to register 5 commits one entry: lower word = write data, upper word = current register 7. The entry is chosen by bank = selector−1, set = register 4 bits [5:4], index = register 4 bits [3:0].
- R5: When the replaced entry had bit 3 of its lower word set, `inval_valid` pulses for the single cycle after the commit request. During that cycle `inval_vpn` holds bits [31:13] of the old upper word; at all other times it is zero.
- R6: A commit that replaces an entry whose lower-word bit 3 is clear produces no invalidate pulse.
- R7: Any read with selector 1 or 2 first loads the addressed entry's upper and lower words into registers 6 and 5 of that bank. A read of register 6 or 5 therefore returns the entry words.
- R8: With selector 0 or 3, writes to registers 5 and 6 touch only the written register: there is no commit, no cause update and no invalidate. Reads do not refresh.
- R9: Buffer banks 0 and 1 are independent: a commit through selector 1 is not visible through selector 2.
- R10: Reads never raise `inval_valid`, and writes never raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 2 | Register bank selector; values 1 and 2 enable buffer side effects |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Special register number |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| inval_valid | output | 1 | One-cycle page-invalidate request |
| inval_vpn | output | 19 | Virtual page number to invalidate, zero when idle |

## Verification
The assertions assume two things. First, `bank_sel` and the request fields carry known values on every clock edge after reset. Second, `req_write` is only meaningful together with `req_valid`. The stimulus drives every input on the falling edge from the bench, and idles `req_valid` low between requests. Random traffic keeps the selector within its four legal codes and biases register numbers towards 4–7. This keeps commits, cause copies and mirror refreshes frequent, and lets valid and invalid old entries both occur through random lower-word bit 3.

// File: rtl/tlb_regport_pkg.sv
// Shared constants for the banked TLB register access port.
// Assumes register numbers fit the 4-bit special-register address.
package tlb_regport_pkg;
    localparam int SREG_AW    = 4;
    localparam int REG_TSEL   = 4;
    localparam int REG_LO     = 5;
    localparam int REG_HI     = 6;
    localparam int REG_CAUSE  = 7;
    localparam int VALID_BIT  = 3;
    localparam int VPN_LSB    = 13;
endpackage

// File: rtl/tlb_entry_array.sv
// Entry storage for all buffer banks: one shared address, combinational
// read of the addressed entry, synchronous write. Assumes bank/set/idx are
// in range (guaranteed by their widths when counts are powers of two).
module tlb_entry_array #(
    parameter int NBANK = 2,
    parameter int NSET  = 4,
    parameter int NENT  = 16,
    parameter int DW    = 32,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int SW    = (NSET > 1) ? $clog2(NSET) : 1,
    localparam int IW    = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bank,
    input  logic [SW-1:0] set,
    input  logic [IW-1:0] idx,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_hi,
    input  logic [DW-1:0] wr_lo,
    output logic [DW-1:0] rd_hi,
    output logic [DW-1:0] rd_lo
);
    localparam int DEPTH = NBANK * NSET * NENT;

    logic [DW-1:0] hi_q [DEPTH];
    logic [DW-1:0] lo_q [DEPTH];
    int unsigned   flat;

    // Flatten bank/set/index into one storage slot.
    always_comb flat = ((int'(bank) * NSET) + int'(set)) * NENT + int'(idx);

    // Present the addressed entry.
    always_comb begin
        rd_hi = hi_q[flat];
        rd_lo = lo_q[flat];
    end

    // Clear on reset, otherwise store a committed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hi_q[i] <= '0;
                lo_q[i] <= '0;
            end
        end else if (wr_en) begin
            hi_q[flat] <= wr_hi;
            lo_q[flat] <= wr_lo;
        end
    end
endmodule

// File: rtl/tlb_sreg_file.sv
// Banked special-register file. One bank per selector value. A primary
// port writes any register; side ports update the cause register and the
// two mirror registers. Assumes side writes never hit the register the
// primary port writes in the same cycle (the decoder guarantees this).
module tlb_sreg_file #(
    parameter int NSEL  = 4,
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int HI_N  = 6,
    parameter int LO_N  = 5,
    parameter int CA_N  = 7,
    parameter int TS_N  = 4,
    localparam int SELW = $clog2(NSEL),
    localparam int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel,
    input  logic [AW-1:0]   addr,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    input  logic            cause_we,
    input  logic [DW-1:0]   cause_wdata,
    input  logic            mirror_we,
    input  logic [DW-1:0]   mirror_hi,
    input  logic [DW-1:0]   mirror_lo,
    output logic [DW-1:0]   rdata,
    output logic [DW-1:0]   tsel_q,
    output logic [DW-1:0]   cause_q
);
    logic [DW-1:0] rf_q [NSEL][NREG];

    // Combinational views of the selected bank.
    always_comb begin
        rdata   = rf_q[sel][addr];
        tsel_q  = rf_q[sel][TS_N];
        cause_q = rf_q[sel][CA_N];
    end

    // Reset clears every bank; otherwise apply primary and side writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NSEL; b++)
                for (int r = 0; r < NREG; r++)
                    rf_q[b][r] <= '0;
        end else begin
            if (we)        rf_q[sel][addr] <= wdata;
            if (cause_we)  rf_q[sel][CA_N] <= cause_wdata;
            if (mirror_we) begin
                rf_q[sel][HI_N] <= mirror_hi;
                rf_q[sel][LO_N] <= mirror_lo;
            end
        end
    end
endmodule

// File: rtl/tlb_regport.sv
// Banked TLB register access port: decodes special-register requests,
// applies the cause copy, entry commit and mirror refresh side effects,
// registers read data and emits a page-invalidate pulse. Assumes one
// request per cycle and known inputs after reset.
module tlb_regport
    import tlb_regport_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int NSET  = 4,
    parameter int NENT  = 16,
    parameter int DW    = 32,
    localparam int NSEL = 4,
    localparam int NREG = 1 << SREG_AW,
    localparam int SELW = $clog2(NSEL),
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int SW   = (NSET > 1) ? $clog2(NSET) : 1,
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int VW   = DW - VPN_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SELW-1:0]    bank_sel,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SREG_AW-1:0] req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic               inval_valid,
    output logic [VW-1:0]      inval_vpn
);
    logic            tlb_on;
    logic [SELW-1:0] sel_m1;
    logic [BW-1:0]   ent_bank;
    logic [SW-1:0]   ent_set;
    logic [IW-1:0]   ent_idx;
    logic            is_wr, is_rd, wr_hi, commit, refresh;
    logic [DW-1:0]   rf_rdata, tsel_q, cause_q, ent_hi, ent_lo, rd_next;

    // Decode selector, entry address and request kind.
    always_comb begin
        tlb_on   = (int'(bank_sel) >= 1) && (int'(bank_sel) <= NBANK);
        sel_m1   = bank_sel - SELW'(1);
        ent_bank = BW'(sel_m1);
        ent_set  = tsel_q[IW +: SW];
        ent_idx  = tsel_q[IW-1:0];
        is_wr    = req_valid && req_write;
        is_rd    = req_valid && !req_write;
        wr_hi    = is_wr && tlb_on && (int'(req_addr) == REG_HI);
        commit   = is_wr && tlb_on && (int'(req_addr) == REG_LO);
        refresh  = is_rd && tlb_on;
    end

    tlb_sreg_file #(
        .NSEL(NSEL), .NREG(NREG), .DW(DW),
        .HI_N(REG_HI), .LO_N(REG_LO), .CA_N(REG_CAUSE), .TS_N(REG_TSEL)
    ) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bank_sel),
        .addr       (req_addr),
        .we         (is_wr),
        .wdata      (req_wdata),
        .cause_we   (wr_hi),
        .cause_wdata(req_wdata),
        .mirror_we  (refresh),
        .mirror_hi  (ent_hi),
        .mirror_lo  (ent_lo),
        .rdata      (rf_rdata),
        .tsel_q     (tsel_q),
        .cause_q    (cause_q)
    );

    tlb_entry_array #(
        .NBANK(NBANK), .NSET(NSET), .NENT(NENT), .DW(DW)
    ) u_arr (
        .clk  (clk),
        .rst_n(rst_n),
        .bank (ent_bank),
        .set  (ent_set),
        .idx  (ent_idx),
        .wr_en(commit),
        .wr_hi(cause_q),
        .wr_lo(req_wdata),
        .rd_hi(ent_hi),
        .rd_lo(ent_lo)
    );

    // Read data reflects the mirror refresh made by the same read.
    always_comb begin
        rd_next = rf_rdata;
        if (refresh && int'(req_addr) == REG_HI) rd_next = ent_hi;
        if (refresh && int'(req_addr) == REG_LO) rd_next = ent_lo;
    end

    // Register the read response and the invalidate pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            inval_valid <= 1'b0;
            inval_vpn   <= '0;
        end else begin
            rsp_valid   <= is_rd;
            if (is_rd) rsp_rdata <= rd_next;
            inval_valid <= commit && ent_lo[VALID_BIT];
            inval_vpn   <= (commit && ent_lo[VALID_BIT]) ? ent_hi[DW-1:VPN_LSB] : '0;
        end
    end
endmodule

// File: rtl/tlb_regport_chk.sv
// Temporal checks on the access port, bound to every tlb_regport instance.
// Assumes known inputs after reset.
module tlb_regport_chk #(
    parameter int SELW = 2,
    parameter int AW   = 4,
    parameter int VW   = 19
) (
    input logic            clk,
    input logic            rst_n,
    input logic [SELW-1:0] bank_sel,
    input logic            req_valid,
    input logic            req_write,
    input logic [AW-1:0]   req_addr,
    input logic            rsp_valid,
    input logic            inval_valid,
    input logic [VW-1:0]   inval_vpn
);
    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R2
    AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R10
    AST_INVAL_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inval_valid |-> $past(req_valid && req_write && req_addr == AW'(5))); // R5
    AST_INVAL_TLB_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        inval_valid |-> $past(bank_sel == SELW'(1) || bank_sel == SELW'(2))); // R8
    AST_VPN_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !inval_valid |-> (inval_vpn == '0)); // R5
    AST_RSP_INVAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && inval_valid)); // R10
endmodule

bind tlb_regport tlb_regport_chk #(.SELW(SELW), .AW(tlb_regport_pkg::SREG_AW), .VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_sel   (bank_sel),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .inval_valid(inval_valid),
    .inval_vpn  (inval_vpn)
);

// File: tb/tlb_regport_tb.sv
module tlb_regport_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        inval_valid;
    logic [18:0] inval_vpn;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_rf [4][16];
    logic [31:0] m_hi [2][64];
    logic [31:0] m_lo [2][64];

    always #5 clk = ~clk;

    tlb_regport u_dut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .inval_valid(inval_valid), .inval_vpn(inval_vpn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int slot(input logic [31:0] tsel);
        return int'(tsel[5:4]) * 16 + int'(tsel[3:0]);
    endfunction

    // One request, then an idle cycle; model computes the expected outputs.
    task automatic op(input logic w, input logic [1:0] s, input logic [3:0] a,
                      input logic [31:0] d, input string req);
        logic        tlb = (s == 2'd1 || s == 2'd2);
        int          b = int'(s) - 1;
        logic [31:0] exp_rd = '0;
        logic        exp_inv = 1'b0;
        logic [18:0] exp_vpn = '0;
        @(negedge clk);
        bank_sel = s; req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        if (w) begin
            m_rf[s][a] = d;
            if (tlb && a == 4'd6) m_rf[s][7] = d;
            if (tlb && a == 4'd5) begin
                int k = slot(m_rf[s][4]);
                exp_inv = m_lo[b][k][3];
                exp_vpn = exp_inv ? m_hi[b][k][31:13] : '0;
                m_lo[b][k] = d;
                m_hi[b][k] = m_rf[s][7];
            end
        end else begin
            if (tlb) begin
                int k = slot(m_rf[s][4]);
                m_rf[s][6] = m_hi[b][k];
                m_rf[s][5] = m_lo[b][k];
            end
            exp_rd = m_rf[s][a];
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rsp_valid"}, 32'(rsp_valid), 32'(!w));
        if (!w) chk({req, " rdata"}, rsp_rdata, exp_rd);
        chk({req, " inval_valid"}, 32'(inval_valid), 32'(exp_inv));
        chk({req, " inval_vpn"}, 32'(inval_vpn), 32'(exp_vpn));
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) m_rf[i][j] = '0;
        for (int i = 0; i < 2; i++) for (int j = 0; j < 64; j++) begin
            m_hi[i][j] = '0; m_lo[i][j] = '0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle and storage cleared after reset
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 inval_vpn", 32'(inval_vpn), 32'd0);
        op(1'b0, 2'd1, 4'd6, '0, "R1");
        op(1'b0, 2'd2, 4'd5, '0, "R1");
        // R2: plain register round trip
        op(1'b1, 2'd0, 4'd3, 32'hCAFE0001, "R2");
        op(1'b0, 2'd0, 4'd3, '0, "R2");
        // R3: upper write copies into cause
        op(1'b1, 2'd1, 4'd4, 32'h27, "R3");
        op(1'b1, 2'd1, 4'd6, 32'hABCDE000, "R3");
        op(1'b0, 2'd1, 4'd7, '0, "R3");
        // R4 and R6: commit into an empty slot, no invalidate
        op(1'b1, 2'd1, 4'd6, 32'hABCDE000, "R4");
        op(1'b1, 2'd1, 4'd5, 32'h8, "R6");
        op(1'b0, 2'd1, 4'd6, '0, "R4");
        op(1'b0, 2'd1, 4'd5, '0, "R4");
        // R5: replacing the valid entry pulses the old page once
        op(1'b1, 2'd1, 4'd6, 32'h11110000, "R5");
        op(1'b1, 2'd1, 4'd5, 32'h0, "R5");
        op(1'b0, 2'd1, 4'd7, '0, "R5");
        // R7: read refreshes the upper mirror from the entry
        op(1'b1, 2'd1, 4'd6, 32'h55, "R7");
        op(1'b0, 2'd1, 4'd6, '0, "R7");
        // R8: selectors 0 and 3 have no side effects
        op(1'b1, 2'd3, 4'd6, 32'h1234, "R8");
        op(1'b0, 2'd3, 4'd7, '0, "R8");
        op(1'b1, 2'd0, 4'd5, 32'h8, "R8");
        op(1'b1, 2'd0, 4'd5, 32'h8, "R8");
        op(1'b0, 2'd0, 4'd5, '0, "R8");
        // R9: the other bank still sees an empty slot
        op(1'b1, 2'd2, 4'd4, 32'h27, "R9");
        op(1'b0, 2'd2, 4'd6, '0, "R9");
        op(1'b0, 2'd1, 4'd6, '0, "R9");
        // Random traffic, R10 covered by every response/pulse check
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] a = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                                        : 4'($urandom_range(4, 7));
            logic [31:0] d = $urandom();
            if (a == 4'd4) d = d & 32'h3F;
            op(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), a, d, "R10");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule